// File: doc/BRIEF.md
# Multiplexed LCD Drive Level Sequencer

This block scans the four common electrodes of a segment LCD and, for each of the 32 segment electrodes, chooses the drive level that lights or darkens the pixel at the crossing with the active common. It does not make any analog voltage. Each pin gets a 2-bit code that selects one of four levels supplied from outside the block: 0 = VSS, 1 = V2 (1/3 VLCD), 2 = V1 (2/3 VLCD), 3 = VLCD. A one-cycle frame tick, taken from a slow oscillator, moves the scan forward by one common slot. The drive polarity reverses after each full scan, so every pin-to-pin voltage averages to zero over a frame pair.

The user sets the multiplex ratio (all four commons, or only the first three), the bias scheme (1/3 or 1/2), an active-low inhibit that blanks the display, and a 128-bit pixel array. The pixel for common c and segment s is at bit c*32+s. The top four segment pins can each be turned into a static logic output. A change of multiplex ratio takes effect only while the display is blanked, so a scan already running is never cut short.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the scan is at COM1 (index 0) in the positive phase, and the multiplex ratio is four commons.
- R2: At 1/3 bias, the selected common drives code 3 in the positive phase and code 0 in the negative phase. A non-selected common drives code 1 in the positive phase and code 2 in the negative phase. While not inhibited, exactly one common is at code 0 or code 3.
- R3: Each frame tick moves the selected common forward by one, in the order COM1, COM2, COM3, COM4, then back to COM1. When duty3=1 the order is COM1, COM2, COM3, and COM4 always drives the non-selected level.
- R4: The polarity reverses each time the scan wraps back to COM1. Between two ticks it does not change.
- R5: At 1/3 bias a segment whose pixel bit pix[c*32+s] is 1 for the selected common c drives code 0 in the positive phase and code 3 in the negative phase. A segment whose pixel bit is 0 drives code 2 in the positive phase and code 1 in the negative phase.
- R6: At 1/2 bias (bias2=1), non-selected commons and unlit segments drive code 2 in both phases. Selected commons and lit segments keep their levels from R2 and R5.
- R7: While inh_n=0, every common and every non-port segment drives code 0, and the scan is held at COM1 in the positive phase. After release, the scan starts from that state.
- R8: A change on duty3 while inh_n=1 has no effect on the scan. The new ratio is taken in on the next clock edge at which inh_n=0.
- R9: When port_mask[k]=1, segment pin 28+k drives code 3 if port_val[k]=1 and code 0 if port_val[k]=0. This holds whatever the scan state, the pixels or the inhibit level.
- R10: For every common/segment pair, the drive-level difference summed over two full scans is zero, at either bias and either ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse that moves the scan forward one common slot |
| duty3 | input | 1 | 1 = scan three commons, 0 = scan four commons |
| bias2 | input | 1 | 1 = 1/2 bias, 0 = 1/3 bias |
| inh_n | input | 1 | Display enable, active low inhibit |
| pix | input | 128 | Pixel array, bit c*32+s for common c and segment s |
| port_mask | input | 4 | Per-pin port mode for segment pins 28..31 |
| port_val | input | 4 | Logic value for segment pins in port mode |
| com_lvl | output | 8 | Level code for each common, 2 bits per pin, COM1 in bits 1:0 |
| seg_lvl | output | 64 | Level code for each segment, 2 bits per pin, segment 0 in bits 1:0 |

## Verification
The bench goes after the wrap points. A design that wraps at the wrong count selects COM4 in 1/3 mode, or leaves a dead slot before COM1, and either one breaks the frame-pair DC sums. It applies a multiplex change with the display on, where a design that reloads the ratio straight away shortens the scan at once and moves the polarity flip. It holds inhibit low in the middle of a scan, where a design that only blanks the outputs resumes at the wrong common. It also drives port pins while inhibited and with changing pixels, where a design that sends them through the LCD path shows waveform codes instead of a steady logic level.

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NCOM  = 4,
  parameter int NSEG  = 32,
  parameter int NPORT = 4,
  parameter int LW    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_tick,
  input  logic                   duty3,
  input  logic                   bias2,
  input  logic                   inh_n,
  input  logic [NCOM*NSEG-1:0]   pix,
  input  logic [NPORT-1:0]       port_mask,
  input  logic [NPORT-1:0]       port_val,
  output logic [NCOM*LW-1:0]     com_lvl,
  output logic [NSEG*LW-1:0]     seg_lvl
);

  localparam int IW = (NCOM > 1) ? $clog2(NCOM) : 1;
  localparam int PBASE = NSEG - NPORT;
  localparam logic [IW-1:0] LAST_FULL  = IW'(NCOM - 1);
  localparam logic [IW-1:0] LAST_SHORT = IW'(NCOM - 2);
  localparam logic [LW-1:0] L_VSS  = LW'(0);
  localparam logic [LW-1:0] L_V2   = LW'(1);
  localparam logic [LW-1:0] L_V1   = LW'(2);
  localparam logic [LW-1:0] L_VLCD = LW'(3);

  logic [IW-1:0]   idx;
  logic            neg;
  logic            duty_act;
  logic [IW-1:0]   last;
  logic [NSEG-1:0] row;

  assign last = duty_act ? LAST_SHORT : LAST_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      neg      <= 1'b0;
      duty_act <= 1'b0;
    end else if (!inh_n) begin
      idx      <= '0;
      neg      <= 1'b0;
      duty_act <= duty3;
    end else if (frame_tick) begin
      if (idx == last) begin
        idx <= '0;
        neg <= ~neg;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    row = '0;
    for (int r = 0; r < NCOM; r++)
      if (idx == IW'(r)) row = pix[r*NSEG +: NSEG];
  end

  logic [LW-1:0] com_sel_l, com_idle_l, seg_on_l, seg_off_l;
  assign com_sel_l  = neg ? L_VSS : L_VLCD;
  assign com_idle_l = bias2 ? L_V1 : (neg ? L_V1 : L_V2);
  assign seg_on_l   = neg ? L_VLCD : L_VSS;
  assign seg_off_l  = bias2 ? L_V1 : (neg ? L_V2 : L_V1);

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    logic sel;
    assign sel = (idx == IW'(c)) && (IW'(c) <= last);
    assign com_lvl[c*LW +: LW] = !inh_n ? L_VSS : (sel ? com_sel_l : com_idle_l);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [LW-1:0] lcd_l;
    assign lcd_l = !inh_n ? L_VSS : (row[s] ? seg_on_l : seg_off_l);
    if (s >= PBASE) begin : g_port
      assign seg_lvl[s*LW +: LW] = port_mask[s-PBASE] ?
                                   (port_val[s-PBASE] ? L_VLCD : L_VSS) : lcd_l;
    end else begin : g_lcd
      assign seg_lvl[s*LW +: LW] = lcd_l;
    end
  end

  logic [NCOM-1:0] com_ext;
  always_comb
    for (int c = 0; c < NCOM; c++)
      com_ext[c] = (com_lvl[c*LW +: LW] == L_VSS) || (com_lvl[c*LW +: LW] == L_VLCD);

  p_scan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= last);

  p_one_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inh_n |-> ($countones(com_ext) == 1));

  p_inhibit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |=> (idx == '0) && !neg);

  p_flip_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_n && frame_tick && idx == last) |=> (neg != $past(neg)));

  p_no_flip_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_n && !frame_tick) |=> $stable(neg) && $stable(idx));

  p_duty_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inh_n |=> $stable(duty_act));

endmodule

// File: tb/lcd_mux_seq_tb.sv
module lcd_mux_seq_tb;
  localparam int NC = 4, NS = 32;

  logic clk = 0, rst_n = 0, frame_tick = 0, duty3 = 0, bias2 = 0, inh_n = 1;
  logic [NC*NS-1:0] pix = '0;
  logic [3:0] port_mask = '0, port_val = '0;
  logic [NC*2-1:0] com_lvl;
  logic [NS*2-1:0] seg_lvl;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lcd_mux_seq u_dut (.clk, .rst_n, .frame_tick, .duty3, .bias2, .inh_n, .pix,
                     .port_mask, .port_val, .com_lvl, .seg_lvl);

  // duty3, bias2, seed
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b0, 32'hA5C3_0F81},
    {1'b1, 1'b0, 32'h1234_5678},
    {1'b0, 1'b1, 32'hFFFF_0000},
    {1'b1, 1'b1, 32'h0F0F_F0F0},
    {1'b0, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 32'hFFFF_FFFF}
  };

  function automatic logic [1:0] mcom(int c, int i, bit ng, bit b2, bit on);
    if (!on) return 2'd0;
    if (c == i) return ng ? 2'd0 : 2'd3;
    return b2 ? 2'd2 : (ng ? 2'd2 : 2'd1);
  endfunction

  function automatic logic [1:0] mseg(bit p, bit ng, bit b2, bit on);
    if (!on) return 2'd0;
    if (p) return ng ? 2'd3 : 2'd0;
    return b2 ? 2'd2 : (ng ? 2'd1 : 2'd2);
  endfunction

  function automatic int volt(logic [1:0] code, bit b2);
    if (b2) return (code == 0) ? 0 : (code == 3) ? 6 : 3;
    return 2 * int'(code);
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick;
    frame_tick = 1; cyc(1); frame_tick = 0;
  endtask

  task automatic expect_state(string req, int i, bit ng, bit on);
    logic [NC*2-1:0] ec;
    logic [NS*2-1:0] es;
    for (int c = 0; c < NC; c++) ec[c*2 +: 2] = mcom(c, i, ng, bias2, on);
    for (int s = 0; s < NS; s++) es[s*2 +: 2] = mseg(pix[i*NS+s], ng, bias2, on);
    check(req, {120'd0, com_lvl}, {120'd0, ec});
    check(req, {64'd0, seg_lvl}, {64'd0, es});
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    // R1 reset state: COM1 selected, positive, four commons
    expect_state("R1", 0, 0, 1);
    for (int k = 0; k < 4; k++) begin tick; cyc(1); end
    expect_state("R1 four-common wrap", 0, 1, 1);

    // table walk: R2 R3 R4 R5 R6 R10
    foreach (VEC[v]) begin
      int n;
      int acc [NC][NS];
      inh_n = 0;
      duty3 = VEC[v][33]; bias2 = VEC[v][32];
      pix = {VEC[v][31:0], ~VEC[v][31:0], VEC[v][31:0] ^ 32'h5A5A_C3C3,
             {VEC[v][15:0], VEC[v][31:16]}};
      cyc(2);
      expect_state("R7 inhibit", 0, 0, 0);
      inh_n = 1; cyc(1);
      n = duty3 ? 3 : 4;
      foreach (acc[c, s]) acc[c][s] = 0;
      for (int t = 0; t < 2 * n; t++) begin
        expect_state(bias2 ? "R6 scan" : "R2 R3 R5 scan", t % n, (t / n) % 2, 1);
        for (int c = 0; c < NC; c++)
          for (int s = 0; s < NS; s++)
            acc[c][s] += volt(com_lvl[c*2 +: 2], bias2) - volt(seg_lvl[s*2 +: 2], bias2);
        cyc(2);
        expect_state("R4 hold between ticks", t % n, (t / n) % 2, 1);
        tick; cyc(1);
      end
      begin
        int bad = 0;
        foreach (acc[c, s]) if (acc[c][s] != 0) bad++;
        check("R10 zero DC", bad, 0);
      end
      expect_state("R4 wrap polarity", 0, 0, 1);
    end

    // R8: duty change while on is deferred
    inh_n = 0; duty3 = 0; bias2 = 0; pix = {4{32'h8000_0001}}; cyc(2);
    inh_n = 1; cyc(1);
    duty3 = 1;
    for (int k = 0; k < 3; k++) begin tick; cyc(1); end
    expect_state("R8 COM4 still scanned", 3, 0, 1);
    tick; cyc(1);
    expect_state("R8 wrap after four", 0, 1, 1);
    inh_n = 0; cyc(1); inh_n = 1; cyc(1);
    for (int k = 0; k < 3; k++) begin tick; cyc(1); end
    expect_state("R8 three-common after inhibit", 0, 1, 1);

    // R7: inhibit mid-scan resets scan
    tick; cyc(1);
    expect_state("R7 pre", 1, 1, 1);
    inh_n = 0; tick; cyc(1);
    expect_state("R7 blank", 0, 0, 0);
    inh_n = 1; cyc(1);
    expect_state("R7 restart", 0, 0, 1);

    // R9: port pins
    port_mask = 4'b0101; port_val = 4'b0001; pix = '1;
    cyc(1);
    check("R9 pin28 high", seg_lvl[57:56], 2'd3);
    check("R9 pin30 low", seg_lvl[61:60], 2'd0);
    check("R9 pin29 lcd", seg_lvl[59:58], 2'd0);
    inh_n = 0; cyc(1);
    check("R9 pin28 inhibited", seg_lvl[57:56], 2'd3);
    check("R9 pin29 inhibited", seg_lvl[59:58], 2'd0);
    inh_n = 1; cyc(1); tick; tick; tick; cyc(1);
    check("R9 pin28 after ticks", seg_lvl[57:56], 2'd3);
    port_val = 4'b0100; cyc(1);
    check("R9 pin28 low", seg_lvl[57:56], 2'd0);
    check("R9 pin30 high", seg_lvl[61:60], 2'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule